// File: doc/BRIEF.md
# Phase PWM Latch and Gate Sequencer

This block is the digital heart of one phase of a multiphase buck converter. A clock strobe from the phase timing chain starts each switching pulse, and comparator results decide when the pulse ends. The block turns these into enables for the high-side and low-side gate drivers, plus a command that discharges the PWM ramp. All analog comparators are modelled as digital inputs and pass through a synchronizer first.

The pulse state is a reset-dominant latch. If the latch is still set when the next strobe comes (100 % duty), the high side is forced off. It is re-armed once the ramp is back near its floor. An over-current trip ends the present high-side pulse and drops the next one. A gate sequencer turns the latch state into gate enables. It keeps a dead band between the two gates, where each turn-on waits for the opposite node to be sensed low or for a timeout. It also enforces a minimum on time and a minimum off time for the high side. Fault inputs override the sequencer in a fixed priority.

Top module: `phase_gate_seq`

## Requirements
- R1: A rising strobe sets the latch and clears the ramp discharge. The low-side enable drops first. The high-side enable rises only once the gate-low sense reports 1 or the timeout of R12 has run out.
- R2: While ramp-above-error is 1, the latch is reset and ramp discharge is 1. The high-side enable drops. The low-side enable returns only once the switch-low sense reports 1 or the timeout has run out.
- R3: A strobe edge that arrives together with ramp-above-error leaves the latch reset, and the high side stays off.
- R4: A strobe edge while the latch is still set forces the high side off and asserts ramp discharge. The latch sets again only when ramp-near-floor is 1.
- R5: An over-current trip while the high side is on resets the latch. The next strobe edge is then ignored, and the strobe after that starts a pulse as normal.
- R6: While OVP is 1, the low-side enable is 1 and the high-side enable is 0. This wins over every other input.
- R7: While park, debug or brake is 1 and OVP is 0, both gate enables are 0.
- R8: When output-low and negative-current are both 1, the low-side enable is held at 0. Either one alone has no effect.
- R9: Once the high-side enable rises, it stays 1 for at least MIN_ON cycles unless R6 or R7 applies.
- R10: After the high-side enable falls, it stays 0 for at least MIN_OFF cycles.
- R11: The two gate enables are never 1 in the same cycle. In reset, both are 0 and ramp discharge is 1.
- R12: A dead-band wait that sees no sense response proceeds after NOV_TIMEOUT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Phase clock strobe; its rising edge starts a pulse |
| ramp_above_err_i | input | 1 | Ramp has crossed the error voltage |
| ramp_near_floor_i | input | 1 | Ramp is within range of the reference |
| gatel_low_i | input | 1 | Low-side gate sensed below threshold |
| sw_low_i | input | 1 | Switch node sensed low |
| brake_i | input | 1 | Error voltage below reference |
| ovp_i | input | 1 | Over-voltage comparator |
| oc_i | input | 1 | High-side over-current comparator |
| out_low_i | input | 1 | Sensed output below 75 % of reference |
| neg_cur_i | input | 1 | Negative inductor current flagged |
| park_i | input | 1 | Park or undervoltage request |
| debug_i | input | 1 | Debug isolation request |
| gateh_o | output | 1 | High-side driver enable |
| gatel_o | output | 1 | Low-side driver enable |
| ramp_dis_o | output | 1 | Ramp discharge command |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_ON=16, MIN_OFF=24 and NOV_TIMEOUT=20. MIN_OFF is set longer than a full dead-band handshake, so a pulse started right after turn-off shows the off-time hold rather than the handshake delay. MIN_ON is long enough that a reset arriving soon after turn-on is still seen to be held. NOV_TIMEOUT is short enough to be reached when a sense line is held inactive. The bench models both sense lines from the gate outputs and can hold either one inactive, which reaches the dead-band waits and the timeout path.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   typedef enum logic [2:0] {
      G_PARK    = 3'd0,
      G_TO_LOW  = 3'd1,
      G_LOW     = 3'd2,
      G_TO_HIGH = 3'd3,
      G_HIGH    = 3'd4,
      G_OVP     = 3'd5
   } gate_st_t;

   typedef struct packed {
      logic strobe;
      logic above;
      logic near_floor;
      logic gl_low;
      logic sw_low;
      logic brake;
      logic ovp;
      logic oc;
      logic out_low;
      logic neg_cur;
      logic park;
      logic debug;
   } sense_t;

   localparam int SENSE_W = $bits(sense_t);

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_chk_w
      $error("pgs_sync: WIDTH must be at least 1");
   end
   if (STAGES < 1) begin : g_chk_s
      $error("pgs_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= d_i;
      end
      assign q_o = r;
   end else begin : g_chain
      logic [WIDTH-1:0] r [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) r[i] <= '0;
         end else begin
            r[0] <= d_i;
            for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
         end
      end
      assign q_o = r[STAGES-1];
   end

endmodule

// File: rtl/pgs_pwm_latch.sv
module pgs_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic above_i,
   input  logic near_floor_i,
   input  logic oc_i,
   input  logic gh_on_i,
   output logic q_o
);

   logic strobe_d, set_ev, rst_ev, oc_trip;
   logic q, rearm, skip;

   assign set_ev  = strobe_i & ~strobe_d;
   assign oc_trip = oc_i & gh_on_i;
   assign rst_ev  = above_i | oc_trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
         q        <= 1'b0;
         rearm    <= 1'b0;
         skip     <= 1'b0;
      end else begin
         strobe_d <= strobe_i;
         if (rst_ev) begin
            // reset wins over any simultaneous set
            q     <= 1'b0;
            rearm <= 1'b0;
            if (oc_trip) skip <= 1'b1;
         end else if (set_ev) begin
            if (skip) begin
               skip <= 1'b0;
            end else if (q) begin
               // still high at the next strobe: full duty, force off
               q     <= 1'b0;
               rearm <= 1'b1;
            end else begin
               q     <= 1'b1;
               rearm <= 1'b0;
            end
         end else if (rearm && near_floor_i) begin
            q     <= 1'b1;
            rearm <= 1'b0;
         end
      end
   end

   assign q_o = q;

   p_reset_dom_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ev && set_ev) |=> !q_o);
   p_skip_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && skip && !rst_ev) |=> !q_o);
   p_rearm_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && !near_floor_i && !set_ev) |=> !q_o);

endmodule

// File: rtl/pgs_gate_seq.sv
module pgs_gate_seq
   import pgs_pkg::*;
#(
   parameter int MIN_ON      = 14,
   parameter int MIN_OFF     = 16,
   parameter int NOV_TIMEOUT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic gl_low_i,
   input  logic sw_low_i,
   input  logic ovp_i,
   input  logic off_all_i,
   input  logic srd_blk_i,
   output logic gateh_o,
   output logic gatel_o
);

   localparam int MAX_A  = (MIN_ON > MIN_OFF) ? MIN_ON : MIN_OFF;
   localparam int CNT_MX = (MAX_A > NOV_TIMEOUT) ? MAX_A : NOV_TIMEOUT;
   localparam int CNT_W  = $clog2(CNT_MX + 1);
   localparam logic [CNT_W-1:0] ON_LD   = CNT_W'(MIN_ON - 1);
   localparam logic [CNT_W-1:0] OFF_LD  = CNT_W'(MIN_OFF - 1);
   localparam logic [CNT_W-1:0] WAIT_MX = CNT_W'(NOV_TIMEOUT - 1);

   if (MIN_ON < 2) begin : g_chk_on
      $error("pgs_gate_seq: MIN_ON must be at least 2");
   end
   if (MIN_OFF < 1) begin : g_chk_off
      $error("pgs_gate_seq: MIN_OFF must be at least 1");
   end
   if (NOV_TIMEOUT < 2) begin : g_chk_to
      $error("pgs_gate_seq: NOV_TIMEOUT must be at least 2");
   end

   gate_st_t st, nxt;
   logic [CNT_W-1:0] on_cnt, off_cnt, wait_cnt;
   logic wait_done;
   logic gh_q, gl_q;

   assign wait_done = (wait_cnt == WAIT_MX);

   always_comb begin
      nxt = st;
      if (ovp_i) begin
         nxt = G_OVP;
      end else if (off_all_i) begin
         nxt = G_PARK;
      end else begin
         unique case (st)
            G_OVP:     nxt = G_LOW;
            G_PARK:    nxt = G_TO_LOW;
            G_LOW:     if (req_i && off_cnt == '0) nxt = G_TO_HIGH;
            G_TO_HIGH: begin
               if (!req_i)                     nxt = G_TO_LOW;
               else if (gl_low_i || wait_done) nxt = G_HIGH;
            end
            G_HIGH:    if (!req_i && on_cnt == '0) nxt = G_TO_LOW;
            G_TO_LOW:  if (sw_low_i || wait_done) nxt = G_LOW;
            default:   nxt = G_PARK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= G_PARK;
         on_cnt   <= '0;
         off_cnt  <= '0;
         wait_cnt <= '0;
         gh_q     <= 1'b0;
         gl_q     <= 1'b0;
      end else begin
         st <= nxt;
         if (nxt != st)       wait_cnt <= '0;
         else if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
         if (nxt == G_HIGH && st != G_HIGH) on_cnt <= ON_LD;
         else if (on_cnt != '0)             on_cnt <= on_cnt - 1'b1;
         if (st == G_HIGH && nxt != G_HIGH) off_cnt <= OFF_LD;
         else if (off_cnt != '0)            off_cnt <= off_cnt - 1'b1;
         gh_q <= (nxt == G_HIGH);
         gl_q <= (nxt == G_OVP) || (nxt == G_LOW && !srd_blk_i);
      end
   end

   assign gateh_o = gh_q;
   assign gatel_o = gl_q;

   p_no_overlap_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !(gateh_o && gatel_o));
   p_ovp_force_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ovp_i |=> (gatel_o && !gateh_o));
   p_park_low_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (off_all_i && !ovp_i) |=> (!gatel_o && !gateh_o));
   p_srd_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (srd_blk_i && !ovp_i) |=> !gatel_o);
   p_min_on_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gateh_o) && !ovp_i && !off_all_i) |=> gateh_o);

endmodule

// File: rtl/phase_gate_seq.sv
module phase_gate_seq
   import pgs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_ON      = 14,
   parameter int MIN_OFF     = 16,
   parameter int NOV_TIMEOUT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic ramp_above_err_i,
   input  logic ramp_near_floor_i,
   input  logic gatel_low_i,
   input  logic sw_low_i,
   input  logic brake_i,
   input  logic ovp_i,
   input  logic oc_i,
   input  logic out_low_i,
   input  logic neg_cur_i,
   input  logic park_i,
   input  logic debug_i,
   output logic gateh_o,
   output logic gatel_o,
   output logic ramp_dis_o
);

   sense_t raw, syn;
   logic [SENSE_W-1:0] syn_vec;
   logic q, off_all, srd_blk, gh, gl;

   always_comb begin
      raw            = '0;
      raw.strobe     = strobe_i;
      raw.above      = ramp_above_err_i;
      raw.near_floor = ramp_near_floor_i;
      raw.gl_low     = gatel_low_i;
      raw.sw_low     = sw_low_i;
      raw.brake      = brake_i;
      raw.ovp        = ovp_i;
      raw.oc         = oc_i;
      raw.out_low    = out_low_i;
      raw.neg_cur    = neg_cur_i;
      raw.park       = park_i;
      raw.debug      = debug_i;
   end

   pgs_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn_vec)
   );
   assign syn = sense_t'(syn_vec);

   pgs_pwm_latch u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_i     (syn.strobe),
      .above_i      (syn.above),
      .near_floor_i (syn.near_floor),
      .oc_i         (syn.oc),
      .gh_on_i      (gh),
      .q_o          (q)
   );

   assign off_all = syn.park | syn.debug | syn.brake;
   assign srd_blk = syn.out_low & syn.neg_cur;

   pgs_gate_seq #(
      .MIN_ON      (MIN_ON),
      .MIN_OFF     (MIN_OFF),
      .NOV_TIMEOUT (NOV_TIMEOUT)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (q),
      .gl_low_i  (syn.gl_low),
      .sw_low_i  (syn.sw_low),
      .ovp_i     (syn.ovp),
      .off_all_i (off_all),
      .srd_blk_i (srd_blk),
      .gateh_o   (gh),
      .gatel_o   (gl)
   );

   assign gateh_o    = gh;
   assign gatel_o    = gl;
   assign ramp_dis_o = ~q;

   p_dis_when_low_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_dis_o && !$past(ramp_dis_o) && !syn.ovp && !off_all) |=> !$rose(gateh_o));

endmodule

// File: tb/phase_gate_seq_tb.sv
module phase_gate_seq_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 0, above = 0, near_floor = 0, brake = 0, ovp = 0, oc = 0;
   logic out_low = 0, neg_cur = 0, park = 0, debug = 0;
   logic blk_gl = 0, blk_sw = 0;
   logic gl_low, sw_low, gateh, gatel, ramp_dis;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit overlap_seen = 0;

   typedef struct {
      int    at;
      logic  gh, gl, rd;
      string req;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   assign gl_low = ~gatel & ~blk_gl;
   assign sw_low = ~gateh & ~blk_sw;

   phase_gate_seq #(
      .SYNC_STAGES (2),
      .MIN_ON      (16),
      .MIN_OFF     (24),
      .NOV_TIMEOUT (20)
   ) dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .strobe_i          (strobe),
      .ramp_above_err_i  (above),
      .ramp_near_floor_i (near_floor),
      .gatel_low_i       (gl_low),
      .sw_low_i          (sw_low),
      .brake_i           (brake),
      .ovp_i             (ovp),
      .oc_i              (oc),
      .out_low_i         (out_low),
      .neg_cur_i         (neg_cur),
      .park_i            (park),
      .debug_i           (debug),
      .gateh_o           (gateh),
      .gatel_o           (gatel),
      .ramp_dis_o        (ramp_dis)
   );

   // monitor: pops expected items and compares away from the clock edge
   always @(negedge clk) begin
      if (gateh && gatel) overlap_seen = 1;
      while (sb_q.size() > 0 && sb_q[0].at == cyc) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (gateh !== e.gh || gatel !== e.gl || ramp_dis !== e.rd) begin
            n_fail++;
            $display("FAIL %s: gh/gl/rd actual %b%b%b expected %b%b%b at cycle %0d",
                     e.req, gateh, gatel, ramp_dis, e.gh, e.gl, e.rd, cyc);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input logic gh, input logic gl, input logic rd, input string req);
      exp_t e;
      e.at = cyc + 1; e.gh = gh; e.gl = gl; e.rd = rd; e.req = req;
      sb_q.push_back(e);
      tick(1);
   endtask

   task automatic pulse_strobe();
      strobe = 1; tick(2); strobe = 0;
   endtask

   task automatic wait_gh(input logic v, input int lim, input string req);
      int k = 0;
      while (gateh !== v && k < lim) begin tick(1); k++; end
      n_chk++;
      if (gateh !== v) begin
         n_fail++;
         $display("FAIL %s: gateh actual %b expected %b within %0d cycles", req, gateh, v, lim);
      end
   endtask

   task automatic end_pulse();
      above = 1; tick(30); above = 0; tick(30);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report();
   end

   initial begin
      tick(2);
      expect_out(0, 0, 1, "R11 reset");
      tick(3);
      rst_n = 1;
      tick(10);
      expect_out(0, 1, 1, "R11 idle after reset");

      // R1: set, gate-low wait, then high side
      blk_gl = 1; pulse_strobe(); tick(8);
      expect_out(0, 0, 0, "R1 low side off, high waits");
      blk_gl = 0; tick(20);
      expect_out(1, 0, 0, "R1 high side on");

      // R2: reset by ramp, switch-low wait, then low side
      blk_sw = 1; above = 1; tick(8);
      expect_out(0, 0, 1, "R2 high off, low waits");
      blk_sw = 0; tick(8);
      expect_out(0, 1, 1, "R2 low side on");
      above = 0; tick(30);

      // R12: handshake timeout
      blk_gl = 1; pulse_strobe(); tick(10);
      expect_out(0, 0, 0, "R12 still waiting");
      tick(17);
      expect_out(1, 0, 0, "R12 proceeded after timeout");
      blk_gl = 0; end_pulse();

      // R3: reset-dominant latch
      above = 1; strobe = 1; tick(2); above = 0; strobe = 0; tick(10);
      expect_out(0, 1, 1, "R3 reset dominant");
      tick(10);

      // R4: full duty forced off and re-arm
      pulse_strobe(); tick(18);
      expect_out(1, 0, 0, "R4 first pulse on");
      pulse_strobe(); tick(18);
      expect_out(0, 1, 1, "R4 forced off at next strobe");
      near_floor = 1; tick(39);
      expect_out(1, 0, 0, "R4 re-armed near floor");
      near_floor = 0; end_pulse();

      // R9: minimum on time
      pulse_strobe();
      wait_gh(1, 30, "R9 pulse start");
      above = 1; tick(9);
      expect_out(1, 0, 1, "R9 held by minimum on");
      wait_gh(0, 30, "R9 pulse end");
      // R10: minimum off time
      above = 0; tick(4); pulse_strobe(); tick(13);
      expect_out(0, 1, 0, "R10 held off by minimum off");
      tick(19);
      expect_out(1, 0, 0, "R10 on after minimum off");
      end_pulse();

      // R5: over-current terminate and skip
      pulse_strobe();
      wait_gh(1, 30, "R5 pulse start");
      oc = 1; tick(23);
      expect_out(0, 1, 1, "R5 pulse terminated");
      oc = 0; tick(10);
      pulse_strobe(); tick(29);
      expect_out(0, 1, 1, "R5 next pulse skipped");
      pulse_strobe(); tick(29);
      expect_out(1, 0, 0, "R5 later pulse runs");
      end_pulse();

      // R6 / R7: fault overrides
      pulse_strobe();
      wait_gh(1, 30, "R6 pulse start");
      ovp = 1; park = 1; tick(5);
      expect_out(0, 1, 0, "R6 OVP over park");
      ovp = 0; tick(5);
      expect_out(0, 0, 0, "R7 park both low");
      park = 0; debug = 1; tick(5);
      expect_out(0, 0, 0, "R7 debug both low");
      debug = 0; brake = 1; tick(5);
      expect_out(0, 0, 0, "R7 brake both low");
      brake = 0; above = 1; tick(30);
      expect_out(0, 1, 1, "R7 normal after release");
      above = 0; tick(5);

      // R8: sync-rectifier disable
      out_low = 1; tick(6);
      expect_out(0, 1, 1, "R8 output-low alone");
      neg_cur = 1; tick(6);
      expect_out(0, 0, 1, "R8 low side held off");
      out_low = 0; tick(6);
      expect_out(0, 1, 1, "R8 negative current alone");
      neg_cur = 0; tick(4);

      n_chk++;
      if (overlap_seen) begin
         n_fail++;
         $display("FAIL R11: overlap actual 1 expected 0");
      end
      tick(3);
      report();
   end

endmodule